// File: doc/BRIEF.md
# Periodic Pass/Discard Stream Gate

This block sits in a streaming sample path between an event detector and a memory writer. After a start pulse it runs a series of windows. In each window it first forwards a set number of accepted beats unchanged. It then consumes a set number of beats from upstream and hides them from downstream. After the last window it stops. Because the forwarded beats form one unbroken stream and the final one is marked with `m_tlast`, a single downstream transfer of fixed length collects every sub-capture.

The pass length, discard length and window count are taken from plain inputs when the block starts. An optional reload mode lets a controller supply a new pass length before each window. The gate raises a request and waits, however long it takes, for an acknowledge that carries the value. All counting is in upstream handshakes, so stalls on either side never shorten or lengthen a window.

Top module: `window_gate`

## Requirements
- R1: After reset the gate is idle. `busy`, `done`, `lim_req`, `s_tready`, `m_tvalid` and `m_tlast` are all low.
- R2: In a pass phase, `m_tdata` equals `s_tdata`, `m_tvalid` follows `s_tvalid`, and `s_tready` follows `m_tready`. Exactly the pass length of beats is forwarded, in arrival order.
- R3: In a discard phase, `s_tready` is high and `m_tvalid` is low. Exactly the discard length of beats is consumed and none of them appears downstream.
- R4: Windows run as pass, discard, pass, discard and so on. The last window has no discard phase, and the window count sets how many pass phases occur.
- R5: `m_tlast` is high only on the final beat of the last window's pass phase.
- R6: When the sequence ends, `busy` goes low and `done` goes high. `done` stays high until the next accepted start. While idle, no beat is consumed (`s_tready` is low).
- R7: Phase counters advance only on cycles where `s_tvalid` and `s_tready` are both high. Gaps in `s_tvalid` and low `m_tready` do not change which beats are forwarded.
- R8: A pass or discard length of zero skips that phase, and no beat is forwarded or consumed in it.
- R9: A window count of zero ends the run at once. `done` is high one clock after start, and no beat is taken.
- R10: When `reload_en` is high at start, `lim_req` is raised before every window and held until `lim_ack` is high. The `lim_val` present with `lim_ack` becomes that window's pass length, and the discard length stays unchanged.
- R11: Lengths and window count are sampled only when start is accepted. Later changes on those inputs do not affect the run in progress. `start` is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted when idle) |
| pass_len | input | CNT_W | Beats forwarded per window |
| drop_len | input | CNT_W | Beats discarded between windows |
| num_windows | input | WIN_W | Number of pass windows |
| reload_en | input | 1 | Request a new pass length before each window |
| lim_req | output | 1 | Pass length requested |
| lim_ack | input | 1 | Pass length supplied |
| lim_val | input | CNT_W | Supplied pass length |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (sticky) |
| s_tdata | input | DATA_W | Upstream data |
| s_tvalid | input | 1 | Upstream valid |
| s_tready | output | 1 | Upstream ready |
| m_tdata | output | DATA_W | Downstream data |
| m_tvalid | output | 1 | Downstream valid |
| m_tready | input | 1 | Downstream ready |
| m_tlast | output | 1 | Final forwarded beat |

## Verification
The gate is first driven with a steady source and a sink that is always ready. This shows that the window boundaries fall on the right beat indices, because each dropped index would show up as a data mismatch in the scoreboard. A second run adds gaps in `s_tvalid` and a downstream ready that toggles. This separates counting by handshake from counting by clock. Runs with a zero discard length, a zero pass length and a zero window count exercise each skip path. A reload run, with acknowledges that arrive late and lengths that differ per window, shows that each window takes its own value while the discard length stays fixed.

// File: rtl/wgate_pkg.sv
package wgate_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_PASS = 2'd2,
        ST_DROP = 2'd3
    } gate_st_e;
endpackage

// File: rtl/gate_counter.sv
module gate_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         at_last
);
    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clear)
            count_d = '0;
        else if (step)
            count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else
            count_q <= count_d;
    end

    assign count   = count_q;
    assign at_last = (limit != '0) && (count_q == limit - 1'b1);

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && limit != '0) |-> (count_q < limit));
endmodule

// File: rtl/window_gate.sv
module window_gate #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int WIN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  pass_len,
    input  logic [CNT_W-1:0]  drop_len,
    input  logic [WIN_W-1:0]  num_windows,
    input  logic              reload_en,
    output logic              lim_req,
    input  logic              lim_ack,
    input  logic [CNT_W-1:0]  lim_val,
    output logic              busy,
    output logic              done,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              m_tlast
);
    import wgate_pkg::*;

    typedef struct packed {
        gate_st_e         st;
        logic [CNT_W-1:0] pass_lim;
        logic [CNT_W-1:0] drop_lim;
        logic [WIN_W-1:0] win_lim;
        logic             reload;
        logic             done;
    } gate_regs_t;

    gate_regs_t r_d, r_q;

    logic             hs;
    logic             end_pass, next_win;
    logic             beat_clr, beat_step, beat_last;
    logic             win_clr, win_step, win_last;
    logic [CNT_W-1:0] beat_lim, beat_cnt;
    logic [WIN_W-1:0] win_cnt;

    assign hs       = s_tvalid && s_tready;
    assign beat_lim = (r_q.st == ST_DROP) ? r_q.drop_lim : r_q.pass_lim;

    gate_counter #(.W(CNT_W)) u_beat_ctr (
        .clk(clk), .rst_n(rst_n), .clear(beat_clr), .step(beat_step),
        .limit(beat_lim), .count(beat_cnt), .at_last(beat_last)
    );

    gate_counter #(.W(WIN_W)) u_win_ctr (
        .clk(clk), .rst_n(rst_n), .clear(win_clr), .step(win_step),
        .limit(r_q.win_lim), .count(win_cnt), .at_last(win_last)
    );

    always_comb begin
        r_d       = r_q;
        s_tready  = 1'b0;
        m_tvalid  = 1'b0;
        m_tlast   = 1'b0;
        lim_req   = 1'b0;
        beat_clr  = 1'b0;
        beat_step = 1'b0;
        win_clr   = 1'b0;
        win_step  = 1'b0;
        end_pass  = 1'b0;
        next_win  = 1'b0;

        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.pass_lim = pass_len;
                    r_d.drop_lim = drop_len;
                    r_d.win_lim  = num_windows;
                    r_d.reload   = reload_en;
                    r_d.done     = 1'b0;
                    beat_clr     = 1'b1;
                    win_clr      = 1'b1;
                    if (num_windows == '0)
                        r_d.done = 1'b1;
                    else
                        r_d.st = reload_en ? ST_REQ : ST_PASS;
                end
            end
            ST_REQ: begin
                lim_req = 1'b1;
                if (lim_ack) begin
                    r_d.pass_lim = lim_val;
                    r_d.st       = ST_PASS;
                end
            end
            ST_PASS: begin
                if (r_q.pass_lim == '0) begin
                    end_pass = 1'b1;
                end else begin
                    s_tready = m_tready;
                    m_tvalid = s_tvalid;
                    m_tlast  = s_tvalid && win_last && beat_last;
                    if (hs) begin
                        if (beat_last) begin
                            beat_clr = 1'b1;
                            end_pass = 1'b1;
                        end else begin
                            beat_step = 1'b1;
                        end
                    end
                end
            end
            ST_DROP: begin
                if (r_q.drop_lim == '0) begin
                    next_win = 1'b1;
                end else begin
                    s_tready = 1'b1;
                    if (hs) begin
                        if (beat_last) begin
                            beat_clr = 1'b1;
                            next_win = 1'b1;
                        end else begin
                            beat_step = 1'b1;
                        end
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (end_pass) begin
            if (win_last) begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
            end else begin
                r_d.st = ST_DROP;
            end
        end

        if (next_win) begin
            win_step = 1'b1;
            r_d.st   = r_q.reload ? ST_REQ : ST_PASS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.pass_lim <= '0;
            r_q.drop_lim <= '0;
            r_q.win_lim  <= '0;
            r_q.reload   <= 1'b0;
            r_q.done     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign m_tdata = s_tdata;
    assign busy    = (r_q.st != ST_IDLE);
    assign done    = r_q.done;

    // R2
    fwd_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tready) |-> (s_tvalid && s_tready));
    // R6
    idle_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!s_tready && !m_tvalid && !lim_req));
    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R5
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tlast |-> m_tvalid);
    // R5
    end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tlast && m_tready) |=> (!busy && done));
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_req && !lim_ack) |=> lim_req);
endmodule

// File: tb/window_gate_tb.sv
module window_gate_tb;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int WIN_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [CNT_W-1:0]  pass_len;
    logic [CNT_W-1:0]  drop_len;
    logic [WIN_W-1:0]  num_windows;
    logic              reload_en;
    logic              lim_req;
    logic              lim_ack;
    logic [CNT_W-1:0]  lim_val;
    logic              busy;
    logic              done;
    logic [DATA_W-1:0] s_tdata;
    logic              s_tvalid;
    logic              s_tready;
    logic [DATA_W-1:0] m_tdata;
    logic              m_tvalid;
    logic              m_tready;
    logic              m_tlast;

    int checks = 0;
    int errors = 0;
    logic [DATA_W:0] exp_q[$];
    int rl[4];
    int ri = 0;
    int acks = 0;
    bit bp_mode = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    window_gate #(.DATA_W(DATA_W), .CNT_W(CNT_W), .WIN_W(WIN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pass_len(pass_len),
        .drop_len(drop_len), .num_windows(num_windows), .reload_en(reload_en),
        .lim_req(lim_req), .lim_ack(lim_ack), .lim_val(lim_val), .busy(busy),
        .done(done), .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // downstream ready pattern
    initial begin
        m_tready = 1'b1;
        forever begin
            @(negedge clk);
            cyc++;
            m_tready = !bp_mode || (cyc % 3 != 0);
        end
    end

    // pass length responder (R10)
    initial begin
        lim_ack = 1'b0;
        lim_val = '0;
        forever begin
            @(negedge clk);
            if (lim_req) begin
                repeat (2) @(negedge clk);
                check(lim_req === 1'b1, "R10 req held", lim_req, 1);
                lim_val = CNT_W'(rl[ri]);
                ri++;
                acks++;
                lim_ack = 1'b1;
                @(negedge clk);
                lim_ack = 1'b0;
            end
        end
    end

    // monitor: pops scoreboard on each downstream handshake
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (m_tvalid && m_tready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R3 unexpected beat", m_tdata, 0);
                end else begin
                    logic [DATA_W:0] e;
                    e = exp_q.pop_front();
                    check(m_tdata === e[DATA_W-1:0], "R2 data", m_tdata, e[DATA_W-1:0]);
                    check(m_tlast === e[DATA_W], "R5 last", m_tlast, e[DATA_W]);
                end
            end
        end
    end

    task automatic send(input logic [DATA_W-1:0] d, input int gap);
        bit acc;
        s_tvalid = 1'b1;
        s_tdata  = d;
        forever begin
            #5;
            acc = s_tready;
            @(negedge clk);
            if (acc) break;
        end
        s_tvalid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic run_case(input int p, input int dl, input int n, input bit rel,
                            input int base, input int gap, input string tag);
        int k = 0;
        int total;
        for (int w = 0; w < n; w++) begin
            int pl = rel ? rl[w] : p;
            for (int i = 0; i < pl; i++) begin
                exp_q.push_back({(w == n - 1) && (i == pl - 1), DATA_W'(base + k)});
                k++;
            end
            if (w < n - 1) k += dl;
        end
        total = k;
        ri = 0;
        acks = 0;
        pass_len    = CNT_W'(p);
        drop_len    = CNT_W'(dl);
        num_windows = WIN_W'(n);
        reload_en   = rel;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R11: change inputs after start, run must keep sampled values
        pass_len = CNT_W'(p + 5);
        drop_len = CNT_W'(dl + 3);
        num_windows = WIN_W'(n + 2);
        check(busy === 1'b1 && done === 1'b0, {tag, " R11 busy after start"}, {busy, done}, 2'b10);
        for (int j = 0; j < total; j++) send(DATA_W'(base + j), gap);
        for (int t = 0; t < 60 && !done; t++) @(negedge clk);
        check(done === 1'b1 && busy === 1'b0, {tag, " R6 done"}, {done, busy}, 2'b10);
        check(exp_q.size() == 0, {tag, " R4 all windows forwarded"}, exp_q.size(), 0);
        if (rel) check(acks == n, {tag, " R10 request count"}, acks, n);
        exp_q.delete();
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; s_tvalid = 1'b0; s_tdata = '0;
        pass_len = '0; drop_len = '0; num_windows = '0; reload_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(!busy && !done && !lim_req && !s_tready && !m_tvalid && !m_tlast,
              "R1 reset state", {busy, done, lim_req, s_tready, m_tvalid, m_tlast}, 0);

        // R2 R3 R4 R5 R11 steady source
        run_case(3, 2, 3, 0, 32'h100, 0, "basic");

        // R6: idle gate consumes nothing
        s_tvalid = 1'b1; s_tdata = 32'hdead;
        #5;
        check(!s_tready && !m_tvalid, "R6 idle no consume", {s_tready, m_tvalid}, 0);
        @(negedge clk);
        s_tvalid = 1'b0;

        // R7: source gaps and downstream stalls
        bp_mode = 1;
        run_case(4, 1, 2, 0, 32'h200, 2, "stall R7");
        bp_mode = 0;

        // R8: zero discard length, back-to-back windows
        run_case(2, 0, 3, 0, 32'h300, 0, "R8 zero drop");

        // R8: zero pass length, only discards
        run_case(0, 3, 2, 0, 32'h400, 0, "R8 zero pass");

        // R9: zero windows
        num_windows = '0; pass_len = 16'd4; drop_len = 16'd1; reload_en = 1'b0;
        start = 1'b1;
        s_tvalid = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #5;
        check(done === 1'b1 && busy === 1'b0 && !s_tready, "R9 zero windows",
              {done, busy, s_tready}, 3'b100);
        @(negedge clk);
        s_tvalid = 1'b0;

        // R10: per-window pass length
        rl[0] = 2; rl[1] = 1; rl[2] = 3; rl[3] = 0;
        run_case(7, 2, 3, 1, 32'h500, 1, "R10 reload");

        // R5 again with a single window
        run_case(5, 4, 1, 0, 32'h600, 0, "R5 single");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule